// File: doc/BRIEF.md
# Ping-Pong Buffered TDM Serial Multiplexer

This block merges several one-bit serial channels into a single time-division-multiplexed serial stream. Each input bit period, one sample from every channel is captured together as a single memory word. Bit k of that word belongs to channel k. The words go into a dual-port memory that is split into two equal halves. While the write side fills one half, the read side drains the other. It runs at a clock exactly CH times faster and sweeps the same half once per channel. On each sweep it emits only that channel's bit column, so every output frame holds one contiguous slot per channel.

The input clock and the output clock are frequency-locked at a ratio of CH, and their rising edges coincide. Both sides switch halves at the same frame boundary, which they reach together after a common synchronous reset. Address and slot counters advance on the falling edge of their clock. The memory is written and read on the rising edge. The first frame after reset carries no data, so the valid flag stays low and the output is held at 0. Each output frame carries the input frame captured just before it.

Top module: `tdm_pingpong_mux`

## Requirements
- R1: While reset is applied, and in the first output bit period after it is released, `tdm_valid` and `tdm_out` are both 0.
- R2: During the first output frame after reset, which lasts CH*WORDS output bit periods, `tdm_valid` is 0 and `tdm_out` is 0.
- R3: From the first bit of the second output frame, `tdm_valid` is 1 and stays 1 until reset is applied again.
- R4: An output frame is CH slots of WORDS bits each. Slot s covers frame bit positions s*WORDS to s*WORDS+WORDS-1 and carries only channel s, which is input bit `din[s]`.
- R5: Within a slot, the bits leave in the order they were captured, the earliest first.
- R6: Output frame f (f >= 1) carries exactly the WORDS samples captured during input frame f-1. The two memory halves alternate, so a write never targets the half being read.
- R7: Applying reset mid-stream restarts the block. The next output frame is again invalid, and the frame after it carries the first input frame captured after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Input bit clock; samples are captured on its rising edge |
| rd_clk | input | 1 | Output bit clock, frequency-locked at CH times `wr_clk`, rising edges aligned |
| rst | input | 1 | Synchronous reset, active high, sampled in both clock domains |
| din | input | CH | One sample per channel; bit k belongs to channel k |
| tdm_out | output | 1 | Multiplexed serial output |
| tdm_valid | output | 1 | High when `tdm_out` carries buffered data |

## Verification
The bench sweeps every output bit over several frames. Each frame uses a different input pattern: a hash, per-channel constants, an alternating checkerboard and a second hash. This exposes a lane select that picks the wrong channel, a slot order that is swapped, or bits that leave a slot reversed. Comparing frame f against the samples of frame f-1 catches a half-select polarity error. Such a design would re-emit the half being filled, or lose a frame of latency. It also catches a counter that wraps one word early or late, because every later slot would then shift. A second reset is applied in the middle of a frame, and the first frame after it must be blanked again. This catches a design that keeps its primed state or its counter phase across reset, which would leak stale words into the output.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int unsigned TDM_CH_DEFAULT    = 4;
    localparam int unsigned TDM_WORDS_DEFAULT = 64;

    // Width of an index able to address n items (at least one bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_wr_ctrl.sv
module tdm_wr_ctrl
    import tdm_pkg::*;
#(
    parameter int unsigned WORDS = TDM_WORDS_DEFAULT
) (
    input  logic          wr_clk,
    input  logic          rst,
    output logic [idx_w(WORDS):0] wr_addr,
    output logic          wr_en
);

    localparam int unsigned AW     = idx_w(WORDS);
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          half;
    } wr_state_t;

    wr_state_t st_d, st_q;

    // Pointer steps on the falling edge; reset value sits one step before
    // word 0 of half 0 so the first rising-edge write lands there.
    always_comb begin
        st_d = st_q;
        if (st_q.addr == LAST_A) begin
            st_d.addr = '0;
            st_d.half = ~st_q.half;
        end else begin
            st_d.addr = st_q.addr + 1'b1;
        end
        if (rst) begin
            st_d.addr = LAST_A;
            st_d.half = 1'b1;
        end
    end

    always_ff @(negedge wr_clk) begin
        st_q <= st_d;
    end

    assign wr_addr = {st_q.half, st_q.addr};
    assign wr_en   = ~rst;

endmodule

// File: rtl/tdm_rd_ctrl.sv
module tdm_rd_ctrl
    import tdm_pkg::*;
#(
    parameter int unsigned CH    = TDM_CH_DEFAULT,
    parameter int unsigned WORDS = TDM_WORDS_DEFAULT
) (
    input  logic                  rd_clk,
    input  logic                  rst,
    input  logic [CH-1:0]         rd_word,
    output logic [idx_w(WORDS):0] rd_addr,
    output logic [idx_w(CH)-1:0]  rd_slot,
    output logic                  tdm_out,
    output logic                  tdm_valid
);

    localparam int unsigned AW = idx_w(WORDS);
    localparam int unsigned SW = idx_w(CH);
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);
    localparam logic [SW-1:0] LAST_S = SW'(CH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] slot;
        logic          frm;
        logic          primed;
    } rd_cnt_t;

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          valid;
    } rd_out_t;

    rd_cnt_t cnt_d, cnt_q;
    rd_out_t out_d, out_q;

    // Address, pass (slot) and frame counters: falling edge.
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.addr == LAST_A) begin
            cnt_d.addr = '0;
            if (cnt_q.slot == LAST_S) begin
                cnt_d.slot   = '0;
                cnt_d.frm    = ~cnt_q.frm;
                cnt_d.primed = cnt_q.primed | ~cnt_q.frm;
            end else begin
                cnt_d.slot = cnt_q.slot + 1'b1;
            end
        end else begin
            cnt_d.addr = cnt_q.addr + 1'b1;
        end
        if (rst) begin
            cnt_d.addr   = LAST_A;
            cnt_d.slot   = LAST_S;
            cnt_d.frm    = 1'b1;
            cnt_d.primed = 1'b0;
        end
    end

    always_ff @(negedge rd_clk) begin
        cnt_q <= cnt_d;
    end

    // Lane select and valid travel with the memory read: rising edge.
    always_comb begin
        out_d.slot  = cnt_q.slot;
        out_d.valid = cnt_q.primed;
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge rd_clk) begin
        out_q <= out_d;
    end

    // Reader drains the half the writer is not filling.
    assign rd_addr   = {~cnt_q.frm, cnt_q.addr};
    assign rd_slot   = cnt_q.slot;
    assign tdm_valid = out_q.valid;
    assign tdm_out   = out_q.valid & rd_word[out_q.slot];

endmodule

// File: rtl/tdm_dpram.sv
module tdm_dpram
    import tdm_pkg::*;
#(
    parameter int unsigned WIDTH = TDM_CH_DEFAULT,
    parameter int unsigned DEPTH = 2 * TDM_WORDS_DEFAULT
) (
    input  logic                      wr_clk,
    input  logic                      wr_en,
    input  logic [idx_w(DEPTH)-1:0]   wr_addr,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic                      rd_clk,
    input  logic [idx_w(DEPTH)-1:0]   rd_addr,
    output logic [WIDTH-1:0]          rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/tdm_pingpong_mux.sv
module tdm_pingpong_mux
    import tdm_pkg::*;
#(
    parameter int unsigned CH    = TDM_CH_DEFAULT,
    parameter int unsigned WORDS = TDM_WORDS_DEFAULT
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic [CH-1:0] din,
    output logic          tdm_out,
    output logic          tdm_valid
);

    localparam int unsigned AW    = idx_w(WORDS);
    localparam int unsigned SW    = idx_w(CH);
    localparam int unsigned DEPTH = 2 * WORDS;

    logic [AW:0]    wr_addr_w;
    logic           wr_en_w;
    logic [AW:0]    rd_addr_w;
    logic [SW-1:0]  rd_slot_w;
    logic [CH-1:0]  rd_word_w;

    tdm_wr_ctrl #(.WORDS(WORDS)) u_wr (
        .wr_clk  (wr_clk),
        .rst     (rst),
        .wr_addr (wr_addr_w),
        .wr_en   (wr_en_w)
    );

    tdm_dpram #(.WIDTH(CH), .DEPTH(DEPTH)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (din),
        .rd_clk  (rd_clk),
        .rd_addr (rd_addr_w),
        .rd_data (rd_word_w)
    );

    tdm_rd_ctrl #(.CH(CH), .WORDS(WORDS)) u_rd (
        .rd_clk    (rd_clk),
        .rst       (rst),
        .rd_word   (rd_word_w),
        .rd_addr   (rd_addr_w),
        .rd_slot   (rd_slot_w),
        .tdm_out   (tdm_out),
        .tdm_valid (tdm_valid)
    );

endmodule

// File: rtl/tdm_pingpong_mux_chk.sv
module tdm_pingpong_mux_chk
    import tdm_pkg::*;
#(
    parameter int unsigned CH    = TDM_CH_DEFAULT,
    parameter int unsigned WORDS = TDM_WORDS_DEFAULT
) (
    input logic                  wr_clk,
    input logic                  rd_clk,
    input logic                  rst,
    input logic                  tdm_out,
    input logic                  tdm_valid,
    input logic                  wr_en,
    input logic [idx_w(WORDS):0] wr_addr,
    input logic [idx_w(WORDS):0] rd_addr,
    input logic [idx_w(CH)-1:0]  rd_slot
);

    localparam int unsigned AW = idx_w(WORDS);
    localparam int unsigned SW = idx_w(CH);
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);
    localparam logic [SW-1:0] LAST_S = SW'(CH - 1);

    // R2
    idle_output_low_chk: assert property (@(posedge rd_clk) disable iff (rst)
        !tdm_valid |-> !tdm_out);

    // R3
    valid_holds_chk: assert property (@(posedge rd_clk) disable iff (rst)
        tdm_valid |=> tdm_valid);

    // R6
    halves_disjoint_chk: assert property (@(posedge wr_clk) disable iff (rst)
        wr_en |-> (wr_addr[AW] != rd_addr[AW]));

    // R5
    addr_in_order_chk: assert property (@(negedge rd_clk) disable iff (rst)
        (rd_addr[AW-1:0] != LAST_A) |=> (rd_addr[AW-1:0] == $past(rd_addr[AW-1:0]) + 1'b1));

    // R4
    slot_steps_chk: assert property (@(negedge rd_clk) disable iff (rst)
        (rd_addr[AW-1:0] == LAST_A && rd_slot != LAST_S) |=> (rd_slot == $past(rd_slot) + 1'b1));

    // R4
    slot_holds_chk: assert property (@(negedge rd_clk) disable iff (rst)
        (rd_addr[AW-1:0] != LAST_A) |=> $stable(rd_slot));

endmodule

bind tdm_pingpong_mux tdm_pingpong_mux_chk #(.CH(CH), .WORDS(WORDS)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .tdm_out   (tdm_out),
    .tdm_valid (tdm_valid),
    .wr_en     (wr_en_w),
    .wr_addr   (wr_addr_w),
    .rd_addr   (rd_addr_w),
    .rd_slot   (rd_slot_w)
);

// File: tb/tb_tdm_pingpong_mux.sv
`timescale 1ns/1ps
module tb_tdm_pingpong_mux;

    localparam int CH     = 4;
    localparam int WORDS  = 64;
    localparam int FBITS  = CH * WORDS;
    localparam int NFRM   = 5;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst    = 1'b1;
    logic [CH-1:0] din    = '0;
    logic          tdm_out;
    logic          tdm_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    tdm_pingpong_mux #(.CH(CH), .WORDS(WORDS)) dut (
        .wr_clk    (wr_clk),
        .rd_clk    (rd_clk),
        .rst       (rst),
        .din       (din),
        .tdm_out   (tdm_out),
        .tdm_valid (tdm_valid)
    );

    // 200 MHz output clock; input clock at a quarter, rising edges aligned.
    initial forever #2.5 rd_clk = ~rd_clk;
    initial begin
        #2.5 wr_clk = 1'b1;
        forever #10 wr_clk = ~wr_clk;
    end

    // Sample of channel c, word a, input frame f; the pattern family changes by frame.
    function automatic bit pat(input int f, input int c, input int a);
        case (f % 4)
            0:       return bit'(((f * 29 + c * 7 + a * 3 + (a * a) / 5) >> 1) & 1);
            1:       return bit'(c & 1);
            2:       return bit'((a ^ c) & 1);
            default: return bit'(((a * 11 + c * 5 + (a >> 3) * 13 + f) >> 2) & 1);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp, input int pos);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s bit=%0d actual=%0d expected=%0d", tag, pos, act, exp);
        end
    endtask

    // Release reset just after a shared rising edge, then drive and check NFRM frames.
    task automatic run(input bit second);
        @(posedge wr_clk);
        #1 rst = 1'b0;
        fork
            begin
                for (int k = 0; k < NFRM * WORDS; k++) begin
                    @(negedge wr_clk);
                    #1;
                    for (int c = 0; c < CH; c++) din[c] = pat(k / WORDS, c, k % WORDS);
                end
            end
            begin
                for (int m = 0; m <= NFRM * FBITS; m++) begin
                    @(negedge rd_clk);
                    #1;
                    if (m == 0) begin
                        // R1 (and R7 after a mid-stream reset)
                        check(tdm_valid == 1'b0 && tdm_out == 1'b0, second ? "R7 R1" : "R1",
                              {tdm_valid, tdm_out}, 0, m);
                    end else begin
                        int j = m - 1;
                        int f = j / FBITS;
                        int s = (j / WORDS) % CH;
                        int a = j % WORDS;
                        if (f == 0) begin
                            // R2: first frame blanked
                            check(tdm_valid == 1'b0 && tdm_out == 1'b0, second ? "R7 R2" : "R2",
                                  {tdm_valid, tdm_out}, 0, j);
                        end else begin
                            bit e = pat(f - 1, s, a);
                            // R3: valid from second frame
                            check(tdm_valid == 1'b1, second ? "R7 R3" : "R3", tdm_valid, 1, j);
                            // R4 slot lane, R5 order, R6 previous frame
                            check(tdm_out == e, second ? "R7 R4 R5 R6" : "R4 R5 R6",
                                  tdm_out, e, j);
                        end
                    end
                end
            end
        join
    endtask

    initial begin
        repeat (3) @(posedge wr_clk);
        run(1'b0);
        // Mid-frame reset, held for a few input periods
        @(posedge wr_clk);
        #1 rst = 1'b1;
        din = '1;
        repeat (3) @(posedge wr_clk);
        run(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule